// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a small set of hardware claim flags that two independent ports share. Software on either side uses them to coordinate ownership of a shared resource. A port claims a flag by writing a 0 to it and releases it by writing a 1. When the port reads the flag back, it sees 0 only if it holds that flag. Each flag starts free. If a port asks for a flag the other side holds, the request is remembered and is granted on the clock edge where the holder lets go. If both ports ask for the same free flag on the same edge, the left port wins.

Each port has active-low semaphore select, chip enable, output enable and byte-lane selects, plus a read/write line. A flag access needs the semaphore select low and the chip enable high. A write is taken from data bit 0 when the read/write line rises. A read returns the requesting port's view of the flag on every data bit. Pulling the semaphore select and the chip enable low together while any byte lane is selected is an illegal command. It raises that port's error output and has no other effect. Both ports share a single clock, and the read/write edge is detected by sampling that line on the clock.

Top module: `semflag_unit`

## Requirements
- R1: After reset every flag is free: both ports read all ones from each of the eight flags.
- R2: The flag is chosen by address bits 2:0 only; a change in any higher address bit does not change which flag is read or written.
- R3: A flag access happens only while the port's semaphore select is low and its chip enable is high; otherwise a write changes no flag and the read drive stays low.
- R4: A flag write happens only in the cycle where read/write is sampled high after being sampled low with the access qualified; only data bit 0 is used (0 = claim, 1 = release), and holding read/write low writes nothing.
- R5: While the access is qualified with read/write high and output enable low, the drive output is high and the value on all 16 data bits is the same bit: 0 if this port holds the flag, 1 otherwise; with no read, the data output is zero and the drive output is low.
- R6: Semaphore select low with chip enable low and either byte select low raises the port's error output in that cycle, drives no data and changes no flag.
- R7: Flag reads and writes work whether the byte selects are high or low, as long as chip enable is high.
- R8: A claim on a free flag is granted at the write edge: the claiming port then reads 0 and the other port reads 1.
- R9: A claim on a flag held by the other port is not granted; the claimer keeps reading 1 while the holder keeps reading 0.
- R10: When both ports claim the same free flag on the same edge, the left port is granted, and the two ports never both read 0 from one flag.
- R11: A pending claim is granted on the same edge on which the holder releases the flag.
- R12: A release by the holder frees the flag; a release by the port that does not hold the flag leaves the holder unchanged and withdraws that port's own pending claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_ub_n | input | 1 | Left upper byte select, active low |
| l_lb_n | input | 1 | Left lower byte select, active low |
| l_addr | input | 14 | Left address, bits 2:0 pick the flag |
| l_wdata | input | 16 | Left write data, bit 0 used |
| l_rdata | output | 16 | Left read data |
| l_rdrive | output | 1 | Left read data valid / bus drive |
| l_err | output | 1 | Left illegal-command indication |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_ub_n | input | 1 | Right upper byte select, active low |
| r_lb_n | input | 1 | Right lower byte select, active low |
| r_addr | input | 14 | Right address, bits 2:0 pick the flag |
| r_wdata | input | 16 | Right write data, bit 0 used |
| r_rdata | output | 16 | Right read data |
| r_rdrive | output | 1 | Right read data valid / bus drive |
| r_err | output | 1 | Right illegal-command indication |

## Verification
The bench builds the block with its default parameters: eight flags, a 14-bit address and a 16-bit data word. With only eight flags it can run every one through the full claim, contend, hand-over and release sequence from both sides. It also repeats the simultaneous-claim race on every flag. While it does so it varies the address bits above bit 2, and it drives the unused data bits opposite to bit 0. This makes aliasing and stray data bits visible. The gating, illegal-command and held-low cases are then applied to flags in a known state and read back from both ports.

// File: rtl/semflag_pkg.sv
package semflag_pkg;

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    typedef struct packed {
        logic claim;
        logic free;
    } wr_req_t;

    typedef struct packed {
        holder_e holder;
        logic    wait_l;
        logic    wait_r;
    } flag_state_t;

    // releases first, then new claims become waiting, then a free flag is granted
    function automatic flag_state_t flag_next(input flag_state_t cur,
                                              input wr_req_t     lreq,
                                              input wr_req_t     rreq);
        flag_state_t nxt;
        nxt = cur;
        if (lreq.free) begin
            nxt.wait_l = 1'b0;
            if (nxt.holder == HOLD_LEFT) nxt.holder = HOLD_NONE;
        end
        if (rreq.free) begin
            nxt.wait_r = 1'b0;
            if (nxt.holder == HOLD_RIGHT) nxt.holder = HOLD_NONE;
        end
        if (lreq.claim && nxt.holder != HOLD_LEFT)  nxt.wait_l = 1'b1;
        if (rreq.claim && nxt.holder != HOLD_RIGHT) nxt.wait_r = 1'b1;
        if (nxt.holder == HOLD_NONE) begin
            if (nxt.wait_l) begin
                nxt.holder = HOLD_LEFT;
                nxt.wait_l = 1'b0;
            end else if (nxt.wait_r) begin
                nxt.holder = HOLD_RIGHT;
                nxt.wait_r = 1'b0;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/semflag_port_front.sv
module semflag_port_front
    import semflag_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sem_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              rw,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_fire,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_val,
    output logic              rd_on,
    output logic              bad_combo
);
    logic rw_q;
    logic acc_ok;
    logic unused_bits;

    always_ff @(posedge clk) begin
        if (rst) rw_q <= 1'b1;
        else     rw_q <= rw;
    end

    assign acc_ok    = !sem_n && ce_n;
    assign wr_fire   = acc_ok && rw && !rw_q;
    assign rd_on     = acc_ok && rw && !oe_n;
    assign idx       = addr[IDX_W-1:0];
    assign wr_val    = wdata[0];
    assign bad_combo = !sem_n && !ce_n && (!ub_n || !lb_n);

    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/semflag_bank.sv
module semflag_bank
    import semflag_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            l_fire,
    input  logic [IDX_W-1:0]                l_idx,
    input  logic                            l_val,
    input  logic                            r_fire,
    input  logic [IDX_W-1:0]                r_idx,
    input  logic                            r_val,
    output flag_state_t [NUM_FLAGS-1:0]     flags_q
);
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        wr_req_t     lreq;
        wr_req_t     rreq;
        flag_state_t st_q;
        logic        l_hit;
        logic        r_hit;

        assign l_hit      = l_fire && (l_idx == IDX_W'(g));
        assign r_hit      = r_fire && (r_idx == IDX_W'(g));
        assign lreq.claim = l_hit && !l_val;
        assign lreq.free  = l_hit && l_val;
        assign rreq.claim = r_hit && !r_val;
        assign rreq.free  = r_hit && r_val;

        always_ff @(posedge clk) begin
            if (rst) st_q <= '0;
            else     st_q <= flag_next(st_q, lreq, rreq);
        end

        assign flags_q[g] = st_q;
    end
endmodule

// File: rtl/semflag_read_drive.sv
module semflag_read_drive
    import semflag_pkg::*;
#(
    parameter int      NUM_FLAGS = 8,
    parameter int      IDX_W     = 3,
    parameter int      DATA_W    = 16,
    parameter holder_e MINE      = HOLD_LEFT
) (
    input  flag_state_t [NUM_FLAGS-1:0] flags,
    input  logic                        rd_on,
    input  logic [IDX_W-1:0]            idx,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rdrive
);
    holder_e sel_holder;
    logic    seen_bit;

    assign sel_holder = flags[idx].holder;
    assign seen_bit   = (sel_holder != MINE);
    assign rdata      = rd_on ? {DATA_W{seen_bit}} : '0;
    assign rdrive     = rd_on;
endmodule

// File: rtl/semflag_unit.sv
module semflag_unit
    import semflag_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_rw,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rdrive,
    output logic              l_err,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_rw,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rdrive,
    output logic              r_err
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic             l_fire, r_fire;
    logic [IDX_W-1:0] l_idx, r_idx;
    logic             l_val, r_val;
    logic             l_rd, r_rd;
    flag_state_t [NUM_FLAGS-1:0] flags_q;

    semflag_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_front_l (
        .clk(clk), .rst(rst),
        .sem_n(l_sem_n), .ce_n(l_ce_n), .oe_n(l_oe_n), .rw(l_rw),
        .ub_n(l_ub_n), .lb_n(l_lb_n), .addr(l_addr), .wdata(l_wdata),
        .wr_fire(l_fire), .idx(l_idx), .wr_val(l_val), .rd_on(l_rd), .bad_combo(l_err)
    );

    semflag_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_front_r (
        .clk(clk), .rst(rst),
        .sem_n(r_sem_n), .ce_n(r_ce_n), .oe_n(r_oe_n), .rw(r_rw),
        .ub_n(r_ub_n), .lb_n(r_lb_n), .addr(r_addr), .wdata(r_wdata),
        .wr_fire(r_fire), .idx(r_idx), .wr_val(r_val), .rd_on(r_rd), .bad_combo(r_err)
    );

    semflag_bank #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst),
        .l_fire(l_fire), .l_idx(l_idx), .l_val(l_val),
        .r_fire(r_fire), .r_idx(r_idx), .r_val(r_val),
        .flags_q(flags_q)
    );

    semflag_read_drive #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W),
                         .MINE(HOLD_LEFT)) u_rd_l (
        .flags(flags_q), .rd_on(l_rd), .idx(l_idx), .rdata(l_rdata), .rdrive(l_rdrive)
    );

    semflag_read_drive #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W),
                         .MINE(HOLD_RIGHT)) u_rd_r (
        .flags(flags_q), .rd_on(r_rd), .idx(r_idx), .rdata(r_rdata), .rdrive(r_rdrive)
    );
endmodule

// File: rtl/semflag_chk.sv
module semflag_chk
    import semflag_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        l_sem_n,
    input logic                        l_ce_n,
    input logic                        l_rw,
    input logic [ADDR_W-1:0]           l_addr,
    input logic [DATA_W-1:0]           l_rdata,
    input logic                        l_rdrive,
    input logic                        l_err,
    input logic                        r_sem_n,
    input logic                        r_ce_n,
    input logic                        r_rw,
    input logic [ADDR_W-1:0]           r_addr,
    input logic [DATA_W-1:0]           r_rdata,
    input logic                        r_rdrive,
    input logic                        r_err,
    input flag_state_t [NUM_FLAGS-1:0] flags_q
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic any_held;
    always_comb begin
        any_held = 1'b0;
        for (int i = 0; i < NUM_FLAGS; i++)
            if (flags_q[i].holder != HOLD_NONE) any_held = 1'b1;
    end

    // R1
    reset_free_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !any_held);

    // R3
    l_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (l_sem_n || !l_ce_n) |-> !l_rdrive);

    // R3
    r_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (r_sem_n || !r_ce_n) |-> !r_rdrive);

    // R4
    no_edge_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(l_rw) || !l_rw) && ($past(r_rw) || !r_rw)) |=> $stable(flags_q));

    // R5
    l_replicate_chk: assert property (@(posedge clk) disable iff (rst)
        l_rdrive |-> (l_rdata == '0 || l_rdata == '1));

    // R5
    r_replicate_chk: assert property (@(posedge clk) disable iff (rst)
        r_rdrive |-> (r_rdata == '0 || r_rdata == '1));

    // R6
    l_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        l_err |-> !l_rdrive);

    // R6
    r_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        r_err |-> !r_rdrive);

    // R6
    both_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (l_err && r_err) |=> $stable(flags_q));

    // R10
    exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (l_rdrive && r_rdrive && l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0])
            |-> (l_rdata[0] || r_rdata[0]));
endmodule

bind semflag_unit semflag_chk #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_addr(l_addr),
    .l_rdata(l_rdata), .l_rdrive(l_rdrive), .l_err(l_err),
    .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_addr(r_addr),
    .r_rdata(r_rdata), .r_rdrive(r_rdrive), .r_err(r_err),
    .flags_q(flags_q)
);

// File: tb/semflag_unit_tb.sv
`timescale 1ns/1ps
module semflag_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        l_sem_n, l_ce_n, l_oe_n, l_rw, l_ub_n, l_lb_n;
    logic [13:0] l_addr;
    logic [15:0] l_wdata, l_rdata;
    logic        l_rdrive, l_err;
    logic        r_sem_n, r_ce_n, r_oe_n, r_rw, r_ub_n, r_lb_n;
    logic [13:0] r_addr;
    logic [15:0] r_wdata, r_rdata;
    logic        r_rdrive, r_err;

    semflag_unit u_dut (
        .clk(clk), .rst(rst),
        .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_rw(l_rw),
        .l_ub_n(l_ub_n), .l_lb_n(l_lb_n), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rdrive(l_rdrive), .l_err(l_err),
        .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_rw(r_rw),
        .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rdrive(r_rdrive), .r_err(r_err)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int cyc = 0;

    // model: 0 free, 1 left holds, 2 right holds
    int hold [8];
    bit wl [8];
    bit wr [8];
    bit bsel_low = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        l_sem_n = 1; l_ce_n = 1; l_oe_n = 1; l_rw = 1; l_ub_n = 1; l_lb_n = 1;
        l_addr = '0; l_wdata = '0;
        r_sem_n = 1; r_ce_n = 1; r_oe_n = 1; r_rw = 1; r_ub_n = 1; r_lb_n = 1;
        r_addr = '0; r_wdata = '0;
    endtask

    task automatic model_step(input bit dl, input int fl, input bit bl,
                              input bit dr, input int fr, input bit br);
        for (int f = 0; f < 8; f++) begin
            bit lc, lr, rc, rr;
            lc = dl && fl == f && !bl;  lr = dl && fl == f && bl;
            rc = dr && fr == f && !br;  rr = dr && fr == f && br;
            if (lr) begin wl[f] = 0; if (hold[f] == 1) hold[f] = 0; end
            if (rr) begin wr[f] = 0; if (hold[f] == 2) hold[f] = 0; end
            if (lc && hold[f] != 1) wl[f] = 1;
            if (rc && hold[f] != 2) wr[f] = 1;
            if (hold[f] == 0) begin
                if (wl[f]) begin hold[f] = 1; wl[f] = 0; end
                else if (wr[f]) begin hold[f] = 2; wr[f] = 0; end
            end
        end
    endtask

    // write through bit 0; the other data bits are driven to the opposite value
    task automatic write2(input bit dl, input logic [13:0] al, input bit bl,
                          input bit dr, input logic [13:0] ar, input bit br);
        @(negedge clk);
        if (dl) begin
            l_sem_n = 0; l_ce_n = 1; l_rw = 0; l_addr = al;
            l_wdata = bl ? 16'h0001 : 16'hFFFE;
            l_ub_n = !bsel_low; l_lb_n = !bsel_low;
        end
        if (dr) begin
            r_sem_n = 0; r_ce_n = 1; r_rw = 0; r_addr = ar;
            r_wdata = br ? 16'h0001 : 16'hFFFE;
            r_ub_n = !bsel_low; r_lb_n = !bsel_low;
        end
        @(negedge clk);
        if (dl) l_rw = 1;
        if (dr) r_rw = 1;
        @(negedge clk);
        idle_all();
        model_step(dl, int'(al[2:0]), bl, dr, int'(ar[2:0]), br);
    endtask

    task automatic read_chk(input bit right, input logic [13:0] a, input string req);
        logic [15:0] exp;
        @(negedge clk);
        if (!right) begin
            l_sem_n = 0; l_ce_n = 1; l_rw = 1; l_oe_n = 0; l_addr = a;
        end else begin
            r_sem_n = 0; r_ce_n = 1; r_rw = 1; r_oe_n = 0; r_addr = a;
        end
        #1;
        exp = (hold[a[2:0]] == (right ? 2 : 1)) ? 16'h0000 : 16'hFFFF;
        if (!right) begin
            check(l_rdata == exp, req, int'(l_rdata), int'(exp));
            check(l_rdrive == 1'b1, req, int'(l_rdrive), 1);
        end else begin
            check(r_rdata == exp, req, int'(r_rdata), int'(exp));
            check(r_rdrive == 1'b1, req, int'(r_rdrive), 1);
        end
        idle_all();
    endtask

    task automatic read_both(input int f, input logic [2:0] hi, input string req);
        read_chk(1'b0, {hi, 8'h00, 3'(f)}, req);
        read_chk(1'b1, {~hi, 8'h5A, 3'(f)}, req);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 8; f++) begin hold[f] = 0; wl[f] = 0; wr[f] = 0; end
        idle_all();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state, R5 no-read output
        #1;
        check(l_rdata == 16'h0 && !l_rdrive, "R5 idle left", int'(l_rdata), 0);
        check(r_rdata == 16'h0 && !r_rdrive, "R5 idle right", int'(r_rdata), 0);
        for (int f = 0; f < 8; f++) read_both(f, 3'(f), "R1");

        // R8 R9 R11 R12 R2 R4 per flag, higher address bits varied
        for (int f = 0; f < 8; f++) begin
            logic [13:0] hiA, hiB;
            hiA = {3'(f + 1), 8'hC3, 3'(f)};
            hiB = {3'(7 - f), 8'h3C, 3'(f)};
            write2(1, hiA, 0, 0, '0, 0);
            read_both(f, 3'(f + 2), "R8");
            write2(0, '0, 0, 1, hiB, 0);
            read_both(f, 3'(f), "R9");
            write2(1, hiB, 1, 0, '0, 0);
            read_both(f, 3'(f + 5), "R11");
            write2(1, hiA, 1, 0, '0, 0);
            read_both(f, 3'(f), "R12 non-holder release");
            write2(0, '0, 0, 1, hiA, 1);
            read_both(f, 3'(f + 3), "R12 holder release");
        end

        // R10 simultaneous claims on each flag, then hand-over
        for (int f = 0; f < 8; f++) begin
            write2(1, 14'(f + 8), 0, 1, 14'(f + 64), 0);
            read_both(f, 3'(f), "R10 race");
            write2(1, 14'(f), 1, 0, '0, 0);
            read_both(f, 3'(f), "R11 after race");
            write2(0, '0, 0, 1, 14'(f), 1);
            read_both(f, 3'(f), "R12 after race");
        end

        // R12 withdrawn pending claim
        write2(1, 14'd5, 0, 0, '0, 0);
        write2(0, '0, 0, 1, 14'd5, 0);
        write2(0, '0, 0, 1, 14'd5, 1);
        write2(1, 14'd5, 1, 0, '0, 0);
        read_both(5, 3'd0, "R12 withdrawn");

        // R7 byte selects low with chip enable high
        bsel_low = 1'b1;
        write2(0, '0, 0, 1, 14'd2, 0);
        read_both(2, 3'd1, "R7");
        write2(0, '0, 0, 1, 14'd2, 1);
        read_both(2, 3'd1, "R7");
        bsel_low = 1'b0;

        // R6 forbidden combination on left, flag 3 free
        @(negedge clk);
        l_sem_n = 0; l_ce_n = 0; l_lb_n = 0; l_oe_n = 0; l_rw = 0;
        l_addr = 14'd3; l_wdata = 16'h0000;
        #1;
        check(l_err == 1'b1, "R6 err", int'(l_err), 1);
        check(!l_rdrive && l_rdata == 16'h0, "R6 nodrive", int'(l_rdrive), 0);
        check(r_err == 1'b0, "R6 other err", int'(r_err), 0);
        @(negedge clk);
        l_rw = 1;
        #1;
        check(l_err == 1'b1, "R6 err rw high", int'(l_err), 1);
        check(!l_rdrive && l_rdata == 16'h0, "R6 nodrive read", int'(l_rdata), 0);
        @(negedge clk);
        idle_all();
        #1;
        check(l_err == 1'b0, "R6 err clears", int'(l_err), 0);
        read_both(3, 3'd0, "R6 no change");

        // R6 on right with upper byte, flag held by left
        write2(1, 14'd4, 0, 0, '0, 0);
        @(negedge clk);
        r_sem_n = 0; r_ce_n = 0; r_ub_n = 0; r_rw = 0; r_addr = 14'd4; r_wdata = 16'h0001;
        #1;
        check(r_err == 1'b1, "R6 err right", int'(r_err), 1);
        @(negedge clk);
        r_rw = 1;
        @(negedge clk);
        idle_all();
        read_both(4, 3'd2, "R6 holder kept");

        // R3 semaphore select high: rw rises with claim data, no write, no drive
        @(negedge clk);
        r_sem_n = 1; r_ce_n = 1; r_rw = 0; r_addr = 14'd6; r_wdata = 16'h0000; r_oe_n = 0;
        @(negedge clk);
        r_rw = 1;
        #1;
        check(!r_rdrive && r_rdata == 16'h0, "R3 sem high nodrive", int'(r_rdrive), 0);
        @(negedge clk);
        idle_all();
        read_both(6, 3'd0, "R3 sem high");

        // R3 chip enable low, bytes deselected: not illegal, but no access
        @(negedge clk);
        r_sem_n = 0; r_ce_n = 0; r_rw = 0; r_addr = 14'd6; r_wdata = 16'h0000; r_oe_n = 0;
        #1;
        check(r_err == 1'b0, "R3 ce low no err", int'(r_err), 0);
        @(negedge clk);
        r_rw = 1;
        #1;
        check(!r_rdrive, "R3 ce low nodrive", int'(r_rdrive), 0);
        @(negedge clk);
        idle_all();
        read_both(6, 3'd0, "R3 ce low");

        // R4 rw held low for several cycles, then rises while deselected
        @(negedge clk);
        l_sem_n = 0; l_ce_n = 1; l_rw = 0; l_addr = 14'd7; l_wdata = 16'h0000;
        repeat (3) @(negedge clk);
        l_sem_n = 1; l_rw = 1;
        @(negedge clk);
        idle_all();
        read_both(7, 3'd0, "R4 level no write");

        // R5 read with output enable high: no drive
        @(negedge clk);
        l_sem_n = 0; l_ce_n = 1; l_rw = 1; l_oe_n = 1; l_addr = 14'd4;
        #1;
        check(!l_rdrive && l_rdata == 16'h0, "R5 oe high", int'(l_rdata), 0);
        idle_all();

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule